// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects a set of level-sensitive interrupt requests and steers each one onto one of several interrupt output lines. Software enables or disables each source with a per-source enable bit, and it can read the live input levels. Each source also has a small selector field that either disconnects it or names the output line it drives. All sources that point at the same output are ORed together.

Software reaches the registers through a plain word-wide read/write port. A write commits on the clock edge while the write enable is high. Read data comes back combinationally from the address in the same cycle. There is no latching and no acknowledge. An output stays asserted for as long as a qualifying source level stays high. Software can find the pending set by ANDing the enable word with the status word. If a line fires and that AND is zero, software treats the interrupt as spurious.

Top module: `irq_route_ctrl`

## Requirements
- R1: Output line j (0..14) goes high one clock edge after a source s has irq_i[s]=1, enable bit s=1 and a selector field equal to j+1; otherwise the line is low.
- R2: The enable word sits at byte offset 0x00. It is read/write, and bit n enables source n.
- R3: The status word sits at offset 0x04. It returns irq_i as sampled at the previous clock edge. It is read-only, and a write to it changes no register.
- R4: A selector field of 0 disconnects its source, so that source drives no output whatever its level or enable bit.
- R5: Selector fields are 4 bits, eight to a word, in reversed source order: 0x08 holds sources 31..24, 0x0C holds 23..16, 0x10 holds 15..8 and 0x14 holds 7..0. Bits [4k+3:4k] of a word hold the lowest source of its group plus k. Each word reads back what was written.
- R6: Sources that select the same output are ORed. An output falls one edge after the last qualifying level falls, because nothing is latched.
- R7: While rst_ni is low, the enable word, all selector fields, the status word and every output are zero.
- R8: Any other offset, including a misaligned one, reads as zero, and a write to it changes no register.
- R9: A write to the enable or selector words takes effect at its clock edge. The outputs reflect it one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, committed at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_i | input | 32 | Level interrupt sources |
| irq_o | output | 15 | Routed interrupt output lines |

## Verification
Read data is due in the same cycle as its address, so the bench samples it just after it drives the address at a falling edge. The status word lags irq_i by one rising edge. The bench checks both the stale value before that edge and the fresh value after it. An output follows an input change at the next rising edge and a register write at the second rising edge. The bench checks irq_o at the falling edge that follows each of those edges, and in one case it checks that the output still holds its old value in between.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned N_SRC  = 32;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned N_OUT  = (1 << SEL_W) - 1;
  localparam int unsigned N_RREG = (N_SRC * SEL_W) / DATA_W;
  // word indices (byte offset / 4)
  localparam int unsigned W_MASK  = 0;
  localparam int unsigned W_STAT  = 1;
  localparam int unsigned W_ROUTE = 2;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NSrc  = N_SRC,
  parameter int unsigned SelW  = SEL_W,
  parameter int unsigned DataW = DATA_W,
  parameter int unsigned AddrW = ADDR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AddrW-1:0]      addr_i,
  input  logic                  we_i,
  input  logic [DataW-1:0]      wdata_i,
  output logic [DataW-1:0]      rdata_o,
  input  logic [NSrc-1:0]       irq_i,
  output logic [NSrc-1:0]       mask_o,
  output logic [NSrc*SelW-1:0]  route_o
);
  localparam int unsigned NReg = (NSrc * SelW) / DataW;

  logic [NSrc-1:0]      mask_q, stat_q;
  logic [NSrc*SelW-1:0] route_q;
  logic [AddrW-3:0]     widx;
  logic                 aligned;

  assign widx    = addr_i[AddrW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
      stat_q  <= '0;
    end else begin
      stat_q <= irq_i;
      if (we_i && aligned) begin
        if (int'(widx) == W_MASK) mask_q <= wdata_i[NSrc-1:0];
        for (int k = 0; k < NReg; k++) begin
          // word k of the routing window covers the highest group first
          if (int'(widx) == W_ROUTE + k)
            route_q[(NReg-1-k)*DataW +: DataW] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (int'(widx) == W_MASK) rdata_o[NSrc-1:0] = mask_q;
      if (int'(widx) == W_STAT) rdata_o[NSrc-1:0] = stat_q;
      for (int k = 0; k < NReg; k++) begin
        if (int'(widx) == W_ROUTE + k)
          rdata_o = route_q[(NReg-1-k)*DataW +: DataW];
      end
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
  import irq_route_pkg::*;
#(
  parameter int unsigned NSrc = N_SRC,
  parameter int unsigned SelW = SEL_W,
  parameter int unsigned NOut = (1 << SelW) - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSrc-1:0]      irq_i,
  input  logic [NSrc-1:0]      mask_i,
  input  logic [NSrc*SelW-1:0] route_i,
  output logic [NOut-1:0]      irq_o
);
  logic [NSrc-1:0]            live;
  logic [NOut-1:0][NSrc-1:0]  hit;
  logic [NOut-1:0]            out_d, out_q;

  assign live = irq_i & mask_i;

  for (genvar j = 0; j < NOut; j++) begin : g_out
    for (genvar s = 0; s < NSrc; s++) begin : g_src
      assign hit[j][s] = live[s] && (route_i[s*SelW +: SelW] == SelW'(j + 1));
    end
    assign out_d[j] = |hit[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign irq_o = out_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NSrc  = N_SRC,
  parameter int unsigned SelW  = SEL_W,
  parameter int unsigned DataW = DATA_W,
  parameter int unsigned AddrW = ADDR_W,
  parameter int unsigned NOut  = (1 << SelW) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AddrW-1:0]  addr_i,
  input  logic              we_i,
  input  logic [DataW-1:0]  wdata_i,
  output logic [DataW-1:0]  rdata_o,
  input  logic [NSrc-1:0]   irq_i,
  output logic [NOut-1:0]   irq_o
);
  logic [NSrc-1:0]      mask_q;
  logic [NSrc*SelW-1:0] route_flat;

  irq_route_regs #(
    .NSrc(NSrc), .SelW(SelW), .DataW(DataW), .AddrW(AddrW)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_i   (irq_i),
    .mask_o  (mask_q),
    .route_o (route_flat)
  );

  irq_route_xbar #(
    .NSrc(NSrc), .SelW(SelW), .NOut(NOut)
  ) u_xbar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .mask_i  (mask_q),
    .route_i (route_flat),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int unsigned NSrc  = 32,
  parameter int unsigned SelW  = 4,
  parameter int unsigned DataW = 32,
  parameter int unsigned AddrW = 8,
  parameter int unsigned NOut  = 15
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [AddrW-1:0]     addr_i,
  input logic                 we_i,
  input logic [DataW-1:0]     wdata_i,
  input logic [DataW-1:0]     rdata_o,
  input logic [NSrc-1:0]      irq_i,
  input logic [NOut-1:0]      irq_o,
  input logic [NSrc-1:0]      mask_q,
  input logic [NSrc*SelW-1:0] route_flat
);
  localparam int unsigned NReg = (NSrc * SelW) / DataW;
  localparam logic [AddrW-1:0] AMask = AddrW'(0);
  localparam logic [AddrW-1:0] AStat = AddrW'(4);
  localparam logic [AddrW-1:0] ARLo  = AddrW'(8);
  localparam logic [AddrW-1:0] ARHi  = AddrW'(8 + 4 * (NReg - 1));

  logic armed_q, mapped;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign mapped = (addr_i[1:0] == 2'b00) &&
                  (addr_i == AMask || addr_i == AStat ||
                   (addr_i >= ARLo && addr_i <= ARHi));

  assert_mask_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AMask) |=> mask_q == $past(wdata_i[NSrc-1:0]));

  assert_stat_ro_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AStat) |=> ($stable(mask_q) && $stable(route_flat)));

  assert_stat_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (addr_i == AStat) |-> rdata_o[NSrc-1:0] == $past(irq_i));

  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(mask_q) == '0 || $past(route_flat) == '0) |-> irq_o == '0);

  assert_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(irq_i) == '0) |-> irq_o == '0);

  assert_unmapped_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == '0);

  assert_unmapped_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mapped) |=> ($stable(mask_q) && $stable(route_flat)));
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
  .NSrc(NSrc), .SelW(SelW), .DataW(DataW), .AddrW(AddrW), .NOut(NOut)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_i      (irq_i),
  .irq_o      (irq_o),
  .mask_q     (mask_q),
  .route_flat (route_flat)
);

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] irq_i = '0;
  logic [14:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_route_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_i(irq_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] mask;
    logic [31:0] irq;
    logic [31:0] r08;
    logic [31:0] r0c;
    logic [31:0] r10;
    logic [31:0] r14;
    logic [14:0] exp;
  } vec_t;

  // R1/R4/R5/R6 vectors: field k of 0x14 = source k, of 0x08 = source 24+k
  localparam vec_t VEC [8] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 15'h0001},
    '{32'h0000_0001, 32'h0000_0000, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 15'h0000},
    '{32'h0000_0000, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 15'h0000},
    '{32'h8000_0000, 32'h8000_0000, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 15'h4000},
    '{32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h0000_0000, 15'h0000},
    '{32'h0001_0100, 32'h0001_0000, 32'h0, 32'h0000_0003, 32'h0000_0003, 32'h0, 15'h0004},
    '{32'hFFFF_FFFF, 32'h0400_0020, 32'h0000_0500, 32'h0, 32'h0, 32'h0020_0000, 15'h0012},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0500, 32'h0, 32'h0, 32'h0020_0000, 15'h0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; we_i = 1'b0;
    #1;
    d = rdata_o;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] v;
    // R7: reset state, with all inputs high
    irq_i = '1;
    repeat (3) @(negedge clk_i);
    rd(8'h04, v); chk("R7 status in reset", v, 32'h0);
    rd(8'h00, v); chk("R7 enable in reset", v, 32'h0);
    chk("R7 outputs in reset", {17'h0, irq_o}, 32'h0);
    irq_i = '0;
    rst_ni = 1'b1;
    tick();
    for (int a = 8; a <= 8'h14; a += 4) begin
      rd(8'(a), v); chk("R7 selector after reset", v, 32'h0);
    end

    // vector table
    for (int i = 0; i < 8; i++) begin
      wr(8'h00, VEC[i].mask);
      wr(8'h08, VEC[i].r08);
      wr(8'h0C, VEC[i].r0c);
      wr(8'h10, VEC[i].r10);
      wr(8'h14, VEC[i].r14);
      irq_i = VEC[i].irq;
      tick();
      chk($sformatf("R1 R4 R6 vector %0d", i), {17'h0, irq_o}, {17'h0, VEC[i].exp});
    end

    // R5: readback and field order
    wr(8'h08, 32'h8765_4321); wr(8'h0C, 32'h0FED_CBA9);
    wr(8'h10, 32'h1357_9BDF); wr(8'h14, 32'h2468_ACE0);
    rd(8'h08, v); chk("R5 readback 0x08", v, 32'h8765_4321);
    rd(8'h0C, v); chk("R5 readback 0x0C", v, 32'h0FED_CBA9);
    rd(8'h10, v); chk("R5 readback 0x10", v, 32'h1357_9BDF);
    rd(8'h14, v); chk("R5 readback 0x14", v, 32'h2468_ACE0);
    // source 9: 0x10 field 1 = 0xD -> line 12; source 17: 0x0C field 1 = 0xA -> line 9
    wr(8'h00, 32'h0002_0200);
    irq_i = 32'h0000_0200; tick();
    chk("R5 source 9 to line 12", {17'h0, irq_o}, 32'h1000);
    irq_i = 32'h0002_0000; tick();
    chk("R5 source 17 to line 9", {17'h0, irq_o}, 32'h0200);

    // R2: enable readback
    wr(8'h00, 32'hA5C3_0F96);
    rd(8'h00, v); chk("R2 enable readback", v, 32'hA5C3_0F96);

    // R3: status timing and read-only
    @(negedge clk_i);
    irq_i = 32'h1234_5678;
    rd(8'h04, v); chk("R3 status before edge", v, 32'h0002_0000);
    tick();
    rd(8'h04, v); chk("R3 status after edge", v, 32'h1234_5678);
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R3 status write ignored", v, 32'h1234_5678);
    rd(8'h00, v); chk("R3 enable untouched by status write", v, 32'hA5C3_0F96);

    // R8: unmapped offsets
    rd(8'h18, v); chk("R8 read 0x18", v, 32'h0);
    rd(8'h02, v); chk("R8 misaligned read", v, 32'h0);
    rd(8'hFC, v); chk("R8 read 0xFC", v, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R8 enable unchanged", v, 32'hA5C3_0F96);
    rd(8'h14, v); chk("R8 selector unchanged", v, 32'h2468_ACE0);

    // R9 and R6: source 0 to line 0, then disable, then level drop
    wr(8'h14, 32'h0000_0001); wr(8'h10, 32'h0); wr(8'h0C, 32'h0); wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_0003);
    irq_i = 32'h0000_0003; tick();
    chk("R9 line 0 active", {17'h0, irq_o}, 32'h0001);
    wr(8'h00, 32'h0000_0000);
    chk("R9 output one edge after write still old", {17'h0, irq_o}, 32'h0001);
    tick();
    chk("R9 output cleared next edge", {17'h0, irq_o}, 32'h0000);
    // R6: two sources on line 2, drop them one at a time
    wr(8'h14, 32'h0000_0033); wr(8'h00, 32'h0000_0003);
    irq_i = 32'h0000_0003; tick();
    chk("R6 two sources OR", {17'h0, irq_o}, 32'h0004);
    irq_i = 32'h0000_0002; tick();
    chk("R6 one source left", {17'h0, irq_o}, 32'h0004);
    irq_i = 32'h0000_0000; tick();
    chk("R6 level drop clears", {17'h0, irq_o}, 32'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule